// File: doc/BRIEF.md
# Three-Wire SPI Temperature Sensor Poller

This block reads a digital temperature sensor over a three-wire serial link in which a single data pin carries traffic in both directions. Each `start` pulse runs one complete read. The block pulls chip select low and clocks out a fixed 16-bit command while it drives the shared pin. It then releases the pin and waits for the sensor to finish a conversion, with chip select still low. After the wait it clocks in a 16-bit reading and raises chip select again. The reading is treated as a signed word, its low three bits are dropped by an arithmetic shift, and the result is presented as a temperature in sixteenths of a degree, with a one-cycle `done` strobe.

The sequencer walks through five states. `ST_IDLE` leaves on `start` and goes to `ST_CMD`. `ST_CMD` goes to `ST_GAP` on the falling serial-clock edge that ends the sixteenth command bit. `ST_GAP` goes to `ST_RESP` when the conversion delay has run out. `ST_RESP` goes to `ST_DONE` on the falling edge that ends the sixteenth response bit. `ST_DONE` always returns to `ST_IDLE` after one cycle. The serial clock half-period and the conversion delay are parameters, given in system clock cycles. The integrator sets the half-period so that the serial clock does not exceed 2 MHz, and sets the delay to at least 1 ms.

Top module: `tsp_poller`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `sdio_oe` is 0, `done` is 0 and `temp` is 0.
- R2: A transaction drives `cs_n` low on the cycle after `start` is seen in `ST_IDLE`. `cs_n` stays low through the command, the wait and the response, with exactly one falling edge per transaction. It returns high in the same cycle that `done` is 1.
- R3: The command word 0x8000 is shifted out on `sdio_out` MSB first, 16 bits, in SPI mode 0. The serial clock idles low, `sdio_out` changes only while `sclk` is low, and the sensor samples on each rising edge. `sdio_oe` is 1 for every command bit.
- R4: `sdio_oe` goes to 0 on the falling edge that ends the command. It stays 0 for all response bits. Between the last command rising edge and the first response rising edge, `sclk` stays low for at least WAIT_CYCLES clock cycles while `cs_n` is held low.
- R5: Exactly 16 response bits are sampled from `sdio_in` on rising `sclk` edges. The first bit sampled is bit 15 of the frame.
- R6: `temp` equals the 16-bit received frame read as two's complement and shifted right arithmetically by 3 bits, sign-extended to 16 bits. One LSB is 0.0625 degree.
- R7: `done` is 1 for exactly one cycle per transaction. `temp` changes only in the cycle in which `done` is 1, and otherwise holds its value.
- R8: A `start` pulse while `cs_n` is low is ignored. It produces no extra chip-select edge and no extra `done`, and it does not disturb the transaction in progress.
- R9: Every high phase of `sclk` lasts HALF_CYCLES clock cycles. The first rising edge comes HALF_CYCLES cycles after `cs_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run a read |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low sensor select |
| sdio_oe | output | 1 | Output enable for the shared data pin driver |
| sdio_out | output | 1 | Data driven onto the shared pin while enabled |
| sdio_in | input | 1 | Data read back from the shared pin |
| temp | output | 16 | Signed temperature, 1/16 degree per LSB |
| done | output | 1 | One-cycle strobe when `temp` is updated |

## Verification
The assertions assume that `start` is a synchronous pulse and that `sdio_in` is only meaningful on rising serial-clock edges inside the response phase. The bench keeps to this by raising `start` for one cycle at a falling system-clock edge. Its sensor model changes `sdio_in` only on falling `sclk` edges. The model also flags any rising edge on which the pin driver is enabled in the wrong phase, so a driver fight between block and sensor shows up as a check failure rather than being covered by the stimulus.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_GAP,
        ST_RESP,
        ST_DONE
    } tsp_state_e;
endpackage

// File: rtl/tsp_tick_gen.sv
module tsp_tick_gen #(
    parameter int HALF_CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/tsp_delay.sv
module tsp_delay #(
    parameter int CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt_q;
    logic          active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (arm) begin
            cnt_q    <= CW'(CYCLES - 1);
            active_q <= 1'b1;
        end else if (active_q) begin
            if (cnt_q == '0) begin
                active_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign expired = active_q && (cnt_q == '0);
endmodule

// File: rtl/tsp_shreg.sv
module tsp_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= ld_val;
        end else if (shift) begin
            q <= {q[W-2:0], sin};
        end
    end
endmodule

// File: rtl/tsp_poller.sv
module tsp_poller
    import tsp_pkg::*;
#(
    parameter int          HALF_CYCLES = 25,
    parameter int          WAIT_CYCLES = 100000,
    parameter int          FRAME_BITS  = 16,
    parameter int          FRAC_DROP   = 3,
    parameter logic [15:0] CMD_WORD    = 16'h8000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    output logic                         sclk,
    output logic                         cs_n,
    output logic                         sdio_oe,
    output logic                         sdio_out,
    input  logic                         sdio_in,
    output logic signed [FRAME_BITS-1:0] temp,
    output logic                         done
);
    localparam int BW = $clog2(FRAME_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

    tsp_state_e state_q, state_d;

    logic          run, tick, rise, fall, last_fall, arm, expired;
    logic          ph_q;
    logic [BW-1:0] bit_q;
    logic [FRAME_BITS-1:0] tx_q, rx_q;
    logic          kick;

    assign run       = (state_q == ST_CMD) || (state_q == ST_RESP);
    assign rise      = tick && !ph_q;
    assign fall      = tick && ph_q;
    assign last_fall = fall && (bit_q == LAST_BIT);
    assign kick      = (state_q == ST_IDLE) && start;
    assign arm       = (state_q == ST_CMD) && last_fall;

    tsp_tick_gen #(.HALF_CYCLES(HALF_CYCLES)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    tsp_delay #(.CYCLES(WAIT_CYCLES)) u_delay (
        .clk(clk), .rst_n(rst_n), .arm(arm), .expired(expired)
    );

    tsp_shreg #(.W(FRAME_BITS)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .load(kick), .ld_val(FRAME_BITS'(CMD_WORD)),
        .shift((state_q == ST_CMD) && fall), .sin(1'b0),
        .q(tx_q)
    );

    tsp_shreg #(.W(FRAME_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .load(kick), .ld_val('0),
        .shift((state_q == ST_RESP) && rise), .sin(sdio_in),
        .q(rx_q)
    );

    // Serial clock phase and bit position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= 1'b0;
            bit_q <= '0;
        end else if (!run) begin
            ph_q  <= 1'b0;
            bit_q <= '0;
        end else if (tick) begin
            ph_q <= !ph_q;
            if (ph_q) begin
                bit_q <= (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_d = ST_CMD;
            ST_CMD:  if (last_fall) state_d = ST_GAP;
            ST_GAP:  if (expired)   state_d = ST_RESP;
            ST_RESP: if (last_fall) state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    logic signed [FRAME_BITS-1:0] rx_s;
    assign rx_s = rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n    <= 1'b1;
            sdio_oe <= 1'b0;
            done    <= 1'b0;
            temp    <= '0;
        end else begin
            cs_n    <= !((state_d == ST_CMD) || (state_d == ST_GAP) || (state_d == ST_RESP));
            sdio_oe <= (state_d == ST_CMD);
            done    <= (state_d == ST_DONE);
            if (state_d == ST_DONE) begin
                temp <= rx_s >>> FRAC_DROP;
            end
        end
    end

    assign sclk     = ph_q;
    assign sdio_out = sdio_oe & tx_q[FRAME_BITS-1];
endmodule

// File: rtl/tsp_poller_chk.sv
module tsp_poller_chk #(
    parameter int FRAME_BITS = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sclk,
    input logic                  cs_n,
    input logic                  sdio_oe,
    input logic                  sdio_out,
    input logic                  done,
    input logic [FRAME_BITS-1:0] temp
);
    // R3: serial clock idles low whenever the sensor is deselected
    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R4: pin driver is only enabled with the sensor selected
    p_oe_needs_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> !cs_n);

    // R4: driver is released while the clock is low
    p_oe_release_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdio_oe) |-> !sclk);

    // R3: command data does not move while the clock is high
    p_data_stable_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && sdio_oe) |-> $stable(sdio_out));

    // R2: deselect coincides with the completion strobe
    p_cs_rise_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> done);

    // R7: completion strobe lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: result holds between completions
    p_temp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(temp));
endmodule

bind tsp_poller tsp_poller_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .sdio_oe(sdio_oe), .sdio_out(sdio_out), .done(done), .temp(temp)
);

// File: tb/test_tsp_poller.sv
module test_tsp_poller;
    localparam int HALF = 3;
    localparam int WAIT = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic sclk, cs_n, sdio_oe, sdio_out, sdio_in, done;
    logic signed [15:0] temp;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    tsp_poller #(.HALF_CYCLES(HALF), .WAIT_CYCLES(WAIT)) i_tsp_poller (
        .clk(clk), .rst_n(rst_n), .start(start), .sclk(sclk), .cs_n(cs_n),
        .sdio_oe(sdio_oe), .sdio_out(sdio_out), .sdio_in(sdio_in),
        .temp(temp), .done(done)
    );

    // Sensor model
    logic [15:0] resp = 16'h0000;
    logic [15:0] cmd_cap;
    int nrise, ri, oe_err, gap_cnt, setup_cnt, hi_cnt, hi_min, hi_max;
    int done_cnt, csfall_cnt;
    bit seen_rise;

    always @(negedge cs_n) begin
        nrise = 0; ri = 0; cmd_cap = 16'h0; oe_err = 0; gap_cnt = 0;
        setup_cnt = 0; seen_rise = 0; hi_min = 1000; hi_max = 0;
        csfall_cnt++;
    end

    always @(posedge sclk) if (!cs_n) begin
        if (nrise < 16) begin
            cmd_cap = {cmd_cap[14:0], sdio_out};
            if (!sdio_oe) oe_err++;
        end else if (sdio_oe) begin
            oe_err++;
        end
        nrise++;
        seen_rise = 1;
    end

    always @(negedge sclk) if (!cs_n && nrise > 16) ri++;

    always_comb sdio_in = (ri < 16) ? resp[15 - ri] : 1'b0;

    always @(posedge clk) begin
        if (done) done_cnt++;
        if (!cs_n && !sclk && nrise == 16) gap_cnt++;
        if (!cs_n && !seen_rise) setup_cnt++;
        if (sclk) hi_cnt++;
        else if (hi_cnt > 0) begin
            if (hi_cnt < hi_min) hi_min = hi_cnt;
            if (hi_cnt > hi_max) hi_max = hi_cnt;
            hi_cnt = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic logic signed [15:0] exp_temp(input logic [15:0] frame);
        logic signed [15:0] s;
        s = frame;
        return s >>> 3;
    endfunction

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1; break; end
        end
    endtask

    task automatic t_reset();
        chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
        chk(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
        chk(sdio_oe == 1'b0, "R1 sdio_oe", int'(sdio_oe), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(temp == 16'sd0, "R1 temp", int'(temp), 0);
    endtask

    task automatic t_xfer(input logic [15:0] frame);
        bit ok;
        int d0;
        resp = frame;
        d0 = done_cnt;
        pulse_start();
        chk(cs_n == 1'b0, "R2 cs_n low after start", int'(cs_n), 0);
        wait_done(ok);
        chk(ok, "R7 done seen", int'(ok), 1);
        chk(temp == exp_temp(frame), "R6 temp", int'(temp), int'(exp_temp(frame)));
        chk(cs_n == 1'b1, "R2 cs_n high with done", int'(cs_n), 1);
        chk(cmd_cap == 16'h8000, "R3 command word", int'(cmd_cap), 32'h8000);
        chk(oe_err == 0, "R4 oe per phase", oe_err, 0);
        chk(gap_cnt >= WAIT, "R4 wait length", gap_cnt, WAIT);
        chk(nrise == 32, "R5 rising edges", nrise, 32);
        chk(setup_cnt == HALF, "R9 first edge", setup_cnt, HALF);
        chk(hi_min == HALF && hi_max == HALF, "R9 high phase", hi_max, HALF);
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
        chk(done_cnt == d0 + 1, "R7 done count", done_cnt - d0, 1);
    endtask

    task automatic t_hold();
        logic signed [15:0] held;
        int d0;
        held = temp;
        d0 = done_cnt;
        resp = 16'h5555;
        repeat (100) @(negedge clk);
        chk(temp == held, "R7 temp holds", int'(temp), int'(held));
        chk(done_cnt == d0, "R7 no stray done", done_cnt - d0, 0);
    endtask

    task automatic t_busy_start();
        bit ok;
        int d0, c0;
        resp = 16'h1900;
        d0 = done_cnt;
        c0 = csfall_cnt;
        pulse_start();
        repeat (10) @(negedge clk);
        pulse_start();
        repeat (60) @(negedge clk);
        pulse_start();
        wait_done(ok);
        repeat (20) @(negedge clk);
        chk(csfall_cnt == c0 + 1, "R8 one cs_n edge", csfall_cnt - c0, 1);
        chk(done_cnt == d0 + 1, "R8 one done", done_cnt - d0, 1);
        chk(cmd_cap == 16'h8000, "R8 command intact", int'(cmd_cap), 32'h8000);
        chk(temp == exp_temp(16'h1900), "R8 temp intact", int'(temp), int'(exp_temp(16'h1900)));
        chk(cs_n == 1'b1, "R2 idle after", int'(cs_n), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        done_cnt = 0; csfall_cnt = 0; hi_cnt = 0; nrise = 0; ri = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_xfer(16'h0C80);   // +25 degrees
        t_xfer(16'hE480);   // negative reading
        t_xfer(16'h0007);   // only discarded bits set
        t_xfer(16'hFFFF);   // -1 LSB
        t_xfer(16'h7FFF);   // largest positive
        t_xfer(16'h8000);   // most negative
        t_hold();
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule